// File: doc/BRIEF.md
# Firmware Image Loader

This engine takes a packed firmware image, delivered as a stream of 32-bit words, and places its code and data blocks into two target memories through a plain write port. The image opens with three header words: a signature, an identity word and a payload length in words. The signature shows whether the image was produced in native or reversed byte order. When it is reversed, every later word is byte-swapped on arrival. The payload is held in an internal buffer. It begins with a table of block entries, and the walker follows the entry offsets to find each block's target address, word count and data.

Nothing is written until the whole image has been checked. The header, the table end marker and every block's offset, type and bounds are validated first, and only then are the block words copied out. The result is reported on a done flag together with a 3-bit outcome code.

The stream uses valid/ready. A word moves only in a cycle where both are high. The loader holds ready low from the cycle after an image's final word until the outcome is reported. The source may drop valid between words at any time. The first word accepted while the loader is idle starts a new image. Its length input is sampled on that word, and the image ends after max(1, length/4) words.

Top module: `fw_image_loader`

## Requirements
- R1: A first word of 0xFEEDF00D selects native order. A first word of 0x0DF0EDFE makes the loader byte-swap every later word of that image before using it. Any other first word ends the load with code 1.
- R2: If the sampled length in bytes is not 12 plus four times the header's payload word count (header word 2), the load ends with code 2. This includes images shorter than three words, where the count reads as zero. Code 1 takes priority over code 2.
- R3: Code 3 is reported when bits 27:24 of the identity word (header word 1) differ from the core ID input. It is also reported when legacy-device mode is on and bits 31:28 are nonzero. Codes 1 and 2 take priority over code 3.
- R4: Table entries hold the type in bits 31:24 and the word offset into the payload in bits 23:0. Type 0x0F marks the end of the table. If no entry at a payload index below the payload count has type 0x0F, the load ends with code 4.
- R5: A block offset below (end-marker index + 1), or one where offset + 2 exceeds the payload count, ends the load with code 5.
- R6: A block type other than 0x00 (code memory) or 0x01 (data memory) ends the load with code 6. The offset check comes first within each entry.
- R7: Code 7 is reported in three cases. The first is a payload count larger than the buffer depth; this is checked after the header checks. The second is target address + count exceeding the selected memory size, which is 2048 words, or 4096 when that memory's large-size input is set. The third is offset + 2 + count exceeding the payload count.
- R8: A rejected image causes no memory write at all, even when the failing entry comes after valid ones.
- R9: On success, each block writes word j of its data to address base + j. Blocks go in table order, and the words within a block in rising order. The data-select output is 1 for type 0x01.
- R10: Done rises one cycle after the last write, or after the rejection. It stays high with a stable code (0 on success) until the next image's first word is accepted, which clears both.
- R11: Ready is low from the cycle after an image's final word until done rises, and high whenever the loader is idle.
- R12: After reset, done, the code and the write strobe are 0 and ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid_i | input | 1 | Image word valid |
| s_ready_o | output | 1 | Loader can take a word |
| s_data_i | input | 32 | Image word |
| img_bytes_i | input | 32 | Total image length in bytes, sampled on the first word |
| core_id_i | input | 4 | Target core identity |
| legacy_dev_i | input | 1 | Reject a nonzero device field in the identity word |
| code_mem_large_i | input | 1 | Code memory holds 4096 words (else 2048) |
| data_mem_large_i | input | 1 | Data memory holds 4096 words (else 2048) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_is_data_o | output | 1 | 1 selects data memory, 0 code memory |
| done_o | output | 1 | Load finished |
| err_code_o | output | 3 | Outcome: 0 ok, 1 signature, 2 length, 3 identity, 4 no end marker, 5 offset, 6 type, 7 overflow |

## Verification
The hardest situation to reach is an image whose first blocks are valid and whose later entry is bad. An eager loader would already have written the early blocks by then. The stimulus builds such images for three of the failing checks: a bad type, a data block that runs past the image, and an out-of-range offset. It then confirms that the write strobe stays low throughout. Byte-reversed images are sent with idle gaps in the valid signal, so the swap decision and the word counting are both exercised under irregular arrival.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam logic [31:0] SIG_NATIVE  = 32'hFEEDF00D;
  localparam logic [31:0] SIG_SWAPPED = 32'h0DF0EDFE;
  localparam logic [7:0]  KIND_CODE   = 8'h00;
  localparam logic [7:0]  KIND_DATA   = 8'h01;
  localparam logic [7:0]  KIND_LAST   = 8'h0F;

  typedef enum logic [2:0] {
    E_NONE     = 3'd0,
    E_SIG      = 3'd1,
    E_LENGTH   = 3'd2,
    E_IDENT    = 3'd3,
    E_NOEND    = 3'd4,
    E_OFFSET   = 3'd5,
    E_KIND     = 3'd6,
    E_OVERFLOW = 3'd7
  } fail_e;

  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/fwl_payload_ram.sv
module fwl_payload_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fwl_intake.sv
module fwl_intake
  import fwl_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int BUF_AW    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              s_valid,
  input  logic [31:0]       s_data,
  output logic              s_ready,
  input  logic [31:0]       img_bytes,
  input  logic [3:0]        core_id,
  input  logic              legacy,
  output logic              ram_we,
  output logic [BUF_AW-1:0] ram_waddr,
  output logic [31:0]       ram_wdata,
  output logic              first_acc,
  output logic              last_acc,
  output fail_e             hdr_fail,
  output logic [31:0]       pay_words
);
  logic [31:0] cnt_q, total_q, bytes_q, ident_q, size_q;
  logic        sig_ok_q, swap_q;
  logic        acc;
  logic [31:0] total_eff, word, slot;
  logic        len_ok, ident_ok;

  assign s_ready   = en;
  assign acc       = s_valid && en;
  assign first_acc = acc && (cnt_q == 32'd0);
  assign total_eff = (cnt_q == 32'd0) ? {2'b00, img_bytes[31:2]} : total_q;
  assign last_acc  = acc && ((cnt_q + 32'd1) >= total_eff);
  assign word      = (cnt_q != 32'd0 && swap_q) ? swap_bytes(s_data) : s_data;
  assign slot      = cnt_q - 32'd3;

  assign ram_we    = acc && (cnt_q >= 32'd3) && (slot < 32'(BUF_DEPTH));
  assign ram_waddr = slot[BUF_AW-1:0];
  assign ram_wdata = word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      total_q  <= '0;
      bytes_q  <= '0;
      ident_q  <= '0;
      size_q   <= '0;
      sig_ok_q <= 1'b0;
      swap_q   <= 1'b0;
    end else if (acc) begin
      cnt_q <= last_acc ? 32'd0 : cnt_q + 32'd1;
      if (first_acc) begin
        total_q  <= {2'b00, img_bytes[31:2]};
        bytes_q  <= img_bytes;
        sig_ok_q <= (s_data == SIG_NATIVE) || (s_data == SIG_SWAPPED);
        swap_q   <= (s_data == SIG_SWAPPED);
        ident_q  <= '0;
        size_q   <= '0;
      end
      if (cnt_q == 32'd1) ident_q <= word;
      if (cnt_q == 32'd2) size_q  <= word;
    end
  end

  assign len_ok   = ({2'b00, bytes_q} == (34'd12 + {size_q, 2'b00}));
  assign ident_ok = (ident_q[27:24] == core_id) && !(legacy && ident_q[31:28] != 4'd0);
  assign pay_words = size_q;

  always_comb begin
    if (!sig_ok_q)                        hdr_fail = E_SIG;
    else if (!len_ok)                     hdr_fail = E_LENGTH;
    else if (!ident_ok)                   hdr_fail = E_IDENT;
    else if (size_q > 32'(BUF_DEPTH))     hdr_fail = E_OVERFLOW;
    else                                  hdr_fail = E_NONE;
  end

  // A reversed signature on the first word must turn swapping on (R1)
  assert_swap_detect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cnt_q == 32'd0 && s_data == SIG_SWAPPED) |=> swap_q);
endmodule

// File: rtl/fwl_walker.sv
module fwl_walker
  import fwl_pkg::*;
#(
  parameter int BUF_AW      = 8,
  parameter int MEM_AW      = 12,
  parameter int SMALL_WORDS = 2048,
  parameter int LARGE_WORDS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear,
  input  fail_e             hdr_fail,
  input  logic [31:0]       pay_words,
  input  logic              code_large,
  input  logic              data_large,
  output logic [BUF_AW-1:0] raddr,
  input  logic [31:0]       rdata,
  output logic              busy,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              mem_is_data,
  output logic              done,
  output logic [2:0]        fail_code
);
  localparam logic [32:0] LIM_SMALL = 33'(SMALL_WORDS);
  localparam logic [32:0] LIM_LARGE = 33'(LARGE_WORDS);

  typedef enum logic [3:0] {
    W_IDLE, W_SCAN, W_VENT, W_VADR, W_VCNT,
    W_CENT, W_CADR, W_CCNT, W_COPY, W_END
  } wstate_e;

  wstate_e     st;
  logic [31:0] idx, nblk, off, baddr, bcnt, j;
  logic        kind_data;
  fail_e       code;
  logic        we_q, isd_q, done_q;
  logic [MEM_AW-1:0] addr_q;
  logic [31:0] wdata_q;
  logic [2:0]  fail_q;

  logic [31:0] rd, ent_off;
  logic [7:0]  ent_kind;
  logic [32:0] lim, mem_end, img_end;
  logic        off_bad, kind_bad;

  always_comb begin
    case (st)
      W_SCAN, W_VENT, W_CENT: rd = idx;
      W_VADR, W_CADR:         rd = off;
      W_VCNT, W_CCNT:         rd = off + 32'd1;
      W_COPY:                 rd = off + 32'd2 + j;
      default:                rd = 32'd0;
    endcase
  end
  assign raddr = rd[BUF_AW-1:0];

  assign ent_kind = rdata[31:24];
  assign ent_off  = {8'h00, rdata[23:0]};
  assign off_bad  = (ent_off < nblk + 32'd1) || (ent_off + 32'd2 > pay_words);
  assign kind_bad = (ent_kind != KIND_CODE) && (ent_kind != KIND_DATA);
  assign lim      = kind_data ? (data_large ? LIM_LARGE : LIM_SMALL)
                              : (code_large ? LIM_LARGE : LIM_SMALL);
  assign mem_end  = {1'b0, baddr} + {1'b0, rdata};
  assign img_end  = {1'b0, off} + 33'd2 + {1'b0, rdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; idx <= '0; nblk <= '0; off <= '0; baddr <= '0;
      bcnt <= '0; j <= '0; kind_data <= 1'b0; code <= E_NONE;
      we_q <= 1'b0; isd_q <= 1'b0; addr_q <= '0; wdata_q <= '0;
      done_q <= 1'b0; fail_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (clear) begin
        done_q <= 1'b0;
        fail_q <= '0;
      end
      case (st)
        W_IDLE: if (start) begin
          idx  <= '0;
          code <= hdr_fail;
          st   <= (hdr_fail != E_NONE) ? W_END : W_SCAN;
        end
        W_SCAN: begin
          if (idx >= pay_words) begin
            code <= E_NOEND;
            st   <= W_END;
          end else if (ent_kind == KIND_LAST) begin
            nblk <= idx;
            idx  <= '0;
            st   <= (idx == 32'd0) ? W_END : W_VENT;
          end else begin
            idx <= idx + 32'd1;
          end
        end
        W_VENT: begin
          if (off_bad) begin
            code <= E_OFFSET; st <= W_END;
          end else if (kind_bad) begin
            code <= E_KIND; st <= W_END;
          end else begin
            kind_data <= ent_kind[0];
            off       <= ent_off;
            st        <= W_VADR;
          end
        end
        W_VADR: begin
          baddr <= rdata;
          st    <= W_VCNT;
        end
        W_VCNT: begin
          if (mem_end > lim || img_end > {1'b0, pay_words}) begin
            code <= E_OVERFLOW; st <= W_END;
          end else if (idx + 32'd1 == nblk) begin
            idx <= '0; st <= W_CENT;
          end else begin
            idx <= idx + 32'd1; st <= W_VENT;
          end
        end
        W_CENT: begin
          kind_data <= ent_kind[0];
          off       <= ent_off;
          st        <= W_CADR;
        end
        W_CADR: begin
          baddr <= rdata;
          st    <= W_CCNT;
        end
        W_CCNT: begin
          bcnt <= rdata;
          j    <= '0;
          if (rdata != 32'd0)          st <= W_COPY;
          else if (idx + 32'd1 == nblk) st <= W_END;
          else begin idx <= idx + 32'd1; st <= W_CENT; end
        end
        W_COPY: begin
          we_q    <= 1'b1;
          isd_q   <= kind_data;
          addr_q  <= baddr[MEM_AW-1:0] + j[MEM_AW-1:0];
          wdata_q <= rdata;
          j       <= j + 32'd1;
          if (j + 32'd1 == bcnt) begin
            if (idx + 32'd1 == nblk) st <= W_END;
            else begin idx <= idx + 32'd1; st <= W_CENT; end
          end
        end
        W_END: begin
          done_q <= 1'b1;
          fail_q <= code;
          st     <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign busy        = (st != W_IDLE);
  assign mem_we      = we_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign mem_is_data = isd_q;
  assign done        = done_q;
  assign fail_code   = fail_q;

  // A rejected load leaves the write strobe idle (R8)
  assert_no_write_after_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && fail_q != 3'd0) |-> !we_q);
  // Done never coincides with a pending write (R10)
  assert_write_before_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> !done_q);
  // Every write lands inside the configured memory (R7)
  assert_write_in_memory_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> ({21'd0, addr_q} < (isd_q ? (data_large ? LIM_LARGE : LIM_SMALL)
                                       : (code_large ? LIM_LARGE : LIM_SMALL))));
  // Buffer reads never run past the received payload (R7)
  assert_read_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd <= pay_words);
endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader
  import fwl_pkg::*;
#(
  parameter int BUF_DEPTH   = 256,
  parameter int MEM_AW      = 12,
  parameter int SMALL_WORDS = 2048,
  parameter int LARGE_WORDS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [31:0]       s_data_i,
  input  logic [31:0]       img_bytes_i,
  input  logic [3:0]        core_id_i,
  input  logic              legacy_dev_i,
  input  logic              code_mem_large_i,
  input  logic              data_mem_large_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              mem_is_data_o,
  output logic              done_o,
  output logic [2:0]        err_code_o
);
  localparam int BUF_AW = $clog2(BUF_DEPTH);

  logic              intake_en, start_q, walk_busy;
  logic              ram_we, first_acc, last_acc;
  logic [BUF_AW-1:0] ram_waddr, ram_raddr;
  logic [31:0]       ram_wdata, ram_rdata, pay_words;
  fail_e             hdr_fail;

  assign intake_en = !(start_q || walk_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= last_acc;
  end

  fwl_intake #(.BUF_DEPTH(BUF_DEPTH), .BUF_AW(BUF_AW)) u_intake (
    .clk(clk), .rst_n(rst_n), .en(intake_en),
    .s_valid(s_valid_i), .s_data(s_data_i), .s_ready(s_ready_o),
    .img_bytes(img_bytes_i), .core_id(core_id_i), .legacy(legacy_dev_i),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .first_acc(first_acc), .last_acc(last_acc),
    .hdr_fail(hdr_fail), .pay_words(pay_words)
  );

  fwl_payload_ram #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  fwl_walker #(.BUF_AW(BUF_AW), .MEM_AW(MEM_AW),
               .SMALL_WORDS(SMALL_WORDS), .LARGE_WORDS(LARGE_WORDS)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(start_q), .clear(first_acc),
    .hdr_fail(hdr_fail), .pay_words(pay_words),
    .code_large(code_mem_large_i), .data_large(data_mem_large_i),
    .raddr(ram_raddr), .rdata(ram_rdata), .busy(walk_busy),
    .mem_we(mem_we_o), .mem_addr(mem_addr_o), .mem_wdata(mem_wdata_o),
    .mem_is_data(mem_is_data_o), .done(done_o), .fail_code(err_code_o)
  );

  // The stream is held off in the cycle before the outcome appears (R11)
  assert_ready_low_before_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(!s_ready_o));
  // The outcome holds until a new image begins (R10)
  assert_outcome_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !(s_valid_i && s_ready_o)) |=> (done_o && $stable(err_code_o)));
endmodule

// File: tb/fw_image_loader_bench.sv
module fw_image_loader_bench;
  localparam int BUF_DEPTH = 256;
  localparam logic [31:0] SIG = 32'hFEEDF00D;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, s_valid, s_ready, legacy, cl, dl;
  logic [31:0] s_data, img_bytes;
  logic [3:0]  core;
  logic        mem_we, mem_is_data, done;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [2:0]  err_code;

  fw_image_loader #(.BUF_DEPTH(BUF_DEPTH)) u_fw_image_loader (
    .clk(clk), .rst_n(rst_n), .s_valid_i(s_valid), .s_ready_o(s_ready),
    .s_data_i(s_data), .img_bytes_i(img_bytes), .core_id_i(core),
    .legacy_dev_i(legacy), .code_mem_large_i(cl), .data_mem_large_i(dl),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_is_data_o(mem_is_data), .done_o(done), .err_code_o(err_code)
  );

  int checks = 0, errors = 0;
  logic [31:0] img[$], sent[$];
  int exp_addr[$], exp_data[$], exp_isd[$];
  string cur_req = "R9";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input int kind, input int off);
    return {kind[7:0], off[23:0]};
  endfunction

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // img = signature, identity, count, then payload
  task automatic mk(input logic [31:0] ident, input logic [31:0] pay[$]);
    img = {};
    img.push_back(SIG); img.push_back(ident); img.push_back(pay.size());
    foreach (pay[i]) img.push_back(pay[i]);
  endtask

  function automatic int model(input int unsigned bytes);
    int n, k, off, kind;
    logic [31:0] idw, sz, a, c, e;
    longint lim;
    n = sent.size();
    if (sent[0] != SIG) return 1;
    idw = (n >= 2) ? sent[1] : 32'd0;
    sz  = (n >= 3) ? sent[2] : 32'd0;
    if (longint'(bytes) != 64'd12 + longint'(sz) * 4) return 2;
    if (idw[27:24] != core) return 3;
    if (legacy && idw[31:28] != 4'd0) return 3;
    if (sz > BUF_DEPTH) return 7;
    k = -1;
    for (int i = 0; i < int'(sz); i++)
      if (sent[3+i][31:24] == 8'h0F) begin k = i; break; end
    if (k < 0) return 4;
    for (int b = 0; b < k; b++) begin
      e = sent[3+b]; off = int'(e[23:0]); kind = int'(e[31:24]);
      if (off < k + 1 || off + 2 > int'(sz)) return 5;
      if (kind > 1) return 6;
      a = sent[3+off]; c = sent[3+off+1];
      lim = (kind == 1) ? (dl ? 4096 : 2048) : (cl ? 4096 : 2048);
      if (longint'(a) + longint'(c) > lim) return 7;
      if (longint'(off) + 2 + longint'(c) > longint'(sz)) return 7;
    end
    for (int b = 0; b < k; b++) begin
      e = sent[3+b]; off = int'(e[23:0]);
      a = sent[3+off]; c = sent[3+off+1];
      for (int jj = 0; jj < int'(c); jj++) begin
        exp_addr.push_back(int'(a) + jj);
        exp_data.push_back(int'(sent[3+off+2+jj]));
        exp_isd.push_back(int'(e[24]));
      end
    end
    return 0;
  endfunction

  // Compare every write against the reference queue on each clock
  always @(negedge clk) if (rst_n && mem_we) begin
    if (exp_addr.size() == 0) chk(1'b0, "R8", "unexpected write", mem_addr, 0);
    else begin
      int ea, ed, ei;
      ea = exp_addr.pop_front(); ed = exp_data.pop_front(); ei = exp_isd.pop_front();
      chk(mem_addr == ea[11:0], cur_req, "write address", mem_addr, ea);
      chk(mem_wdata == ed, cur_req, "write data", mem_wdata, ed);
      chk(mem_is_data == ei[0], cur_req, "memory select", mem_is_data, ei);
    end
  end

  task automatic run(input int unsigned bytes, input bit swap, input bit gaps,
                     input int exp_err, input string req);
    int n, got, wait_n;
    cur_req = req;
    n = int'(bytes >> 2); if (n == 0) n = 1;
    sent = {};
    for (int i = 0; i < n; i++) sent.push_back(i < img.size() ? img[i] : 32'd0);
    exp_addr = {}; exp_data = {}; exp_isd = {};
    got = model(bytes);
    chk(got == exp_err, req, "reference outcome", got, exp_err);
    img_bytes = bytes;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin s_valid = 1'b0; @(negedge clk); end
      s_valid = 1'b1;
      s_data  = swap ? bsw(sent[i]) : sent[i];
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      if (i == 0 && n > 1) chk(done == 1'b0, "R10", "done cleared by new image", done, 0);
    end
    s_valid = 1'b0;
    chk(s_ready == 1'b0, "R11", "ready low after final word", s_ready, 0);
    wait_n = 0;
    while (!done && wait_n < 5000) begin @(negedge clk); wait_n++; end
    chk(done == 1'b1, "R10", "done raised", done, 1);
    chk(s_ready == 1'b1, "R11", "ready back with done", s_ready, 1);
    chk(err_code == 3'(exp_err), req, "outcome code", err_code, exp_err);
    chk(exp_addr.size() == 0, req, "writes outstanding", exp_addr.size(), 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && err_code == 3'(exp_err), "R10", "outcome held", err_code, exp_err);
  endtask

  logic [31:0] p[$];
  localparam logic [31:0] ID_OK = 32'h0500_0000;

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; img_bytes = '0;
    core = 4'd5; legacy = 1'b0; cl = 1'b0; dl = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(done == 1'b0, "R12", "done after reset", done, 0);
    chk(err_code == 3'd0, "R12", "code after reset", err_code, 0);
    chk(mem_we == 1'b0, "R12", "strobe after reset", mem_we, 0);
    chk(s_ready == 1'b1, "R12", "ready after reset", s_ready, 1);

    // R9: two blocks, code then data
    p = {ent(0, 3), ent(1, 8), ent(15, 0),
         32'h10, 32'd3, 32'hA1, 32'hA2, 32'hA3,
         32'h7FE, 32'd2, 32'hB1, 32'hB2};
    mk(ID_OK, p);
    run(img.size() * 4, 0, 0, 0, "R9");
    // R1: same image byte-reversed, with gaps
    run(img.size() * 4, 1, 1, 0, "R1");
    // R1: bad signature
    img[0] = 32'h12345678;
    run(img.size() * 4, 0, 0, 1, "R1");
    // R2: length mismatch and a short image
    mk(ID_OK, p);
    run(img.size() * 4 + 4, 0, 0, 2, "R2");
    run(8, 0, 0, 2, "R2");
    // R3: core mismatch, then device field under legacy mode and without
    mk(32'h0300_0000, p);
    run(img.size() * 4, 0, 0, 3, "R3");
    mk(32'h2500_0000, p);
    legacy = 1'b1;
    run(img.size() * 4, 0, 0, 3, "R3");
    legacy = 1'b0;
    run(img.size() * 4, 1, 0, 0, "R3");
    // R4: no end marker
    mk(ID_OK, {ent(0, 2), ent(0, 2), 32'd0, 32'd0});
    run(img.size() * 4, 0, 0, 4, "R4");
    // R5: offset into the table, and past the end after a valid block
    mk(ID_OK, {ent(0, 1), ent(15, 0), 32'd0, 32'd1, 32'h5});
    run(img.size() * 4, 0, 0, 5, "R5");
    mk(ID_OK, {ent(0, 3), ent(0, 5), ent(15, 0), 32'd0, 32'd1, 32'h5});
    run(img.size() * 4, 0, 0, 5, "R5");
    // R6 and R8: bad type after a valid block
    mk(ID_OK, {ent(1, 3), ent(2, 3), ent(15, 0), 32'h20, 32'd1, 32'h77});
    run(img.size() * 4, 0, 0, 6, "R6");
    // R7: code block past a small memory, accepted when large
    mk(ID_OK, {ent(0, 2), ent(15, 0), 32'h7F0, 32'h20});
    for (int i = 0; i < 32; i++) img.push_back(32'hC000 + i);
    img[2] = img.size() - 3;
    run(img.size() * 4, 0, 0, 7, "R7");
    cl = 1'b1;
    run(img.size() * 4, 0, 1, 0, "R7");
    cl = 1'b0;
    // R8: second block count runs past the image
    mk(ID_OK, {ent(0, 3), ent(1, 5), ent(15, 0), 32'h1, 32'd0, 32'h40, 32'd9, 32'h1});
    run(img.size() * 4, 0, 0, 7, "R8");
    // R7: data block at the top of a large data memory
    dl = 1'b1;
    mk(ID_OK, {ent(1, 2), ent(15, 0), 32'hFFE, 32'd2, 32'hD1, 32'hD2});
    run(img.size() * 4, 1, 0, 0, "R7");
    dl = 1'b0;
    run(img.size() * 4, 0, 0, 7, "R7");
    // R7: payload larger than the buffer
    p = {ent(15, 0)};
    for (int i = 0; i < BUF_DEPTH; i++) p.push_back(32'd0);
    mk(ID_OK, p);
    run(img.size() * 4, 0, 0, 7, "R7");
    // R4: end marker first means an empty, successful load
    mk(ID_OK, {ent(15, 0)});
    run(img.size() * 4, 0, 0, 0, "R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule